// File: doc/BRIEF.md
# Group-Lookahead Adder/Subtractor

This block adds or subtracts two unsigned operands of a parameterized width in pure combinational logic. The operands are cut into 4-bit slices. Inside each slice every carry is formed directly from generate and propagate terms of the lower bits. Between slices the carry passes from one slice to the next, so the slowest path grows with the number of slices and not with the number of bits.

A single mode input picks the operation. With the mode low, the block returns A + B + carry-in. With the mode high, the same adder computes A − B: the B operand is inverted bit by bit, and the carry into the lowest slice is forced to one, which overrides the external carry-in. The carry out of the top slice is also reported. In subtract mode it reads as "no borrow". A flag for signed two's-complement overflow is provided as well, for callers that treat the operands as signed. The block has no clock and no state, and it is meant to sit inside a larger datapath.

Top module: `gra_addsub`

## Requirements
- R1: With `sub_mode`=0, {`carry_out`,`result`} equals `opnd_a` + `opnd_b` + `carry_in`, taken as an unsigned value of WIDTH+1 bits.
- R2: With `sub_mode`=1, `result` equals (`opnd_a` − `opnd_b`) modulo 2^WIDTH.
- R3: With `sub_mode`=1, `carry_out` is 1 exactly when `opnd_a` ≥ `opnd_b` (no borrow), and 0 when a borrow occurs.
- R4: A carry generated in the lowest bit propagates through every 4-bit slice boundary. For example, 16'hFFFF + 0 + 1 gives `result`=0 and `carry_out`=1, and 16'h000F + 1 gives 16'h0010. Every internal carry equals 1 exactly when at least two of its bit's inputs (A bit, effective B bit, carry into that bit) are 1.
- R5: `ovf_signed` is 1 exactly when the two's-complement result does not fit in WIDTH bits. In add mode, that is when the operand sign bits (bit WIDTH−1) are equal and differ from the result's sign bit. In subtract mode, that is when the operand sign bits differ and the result's sign bit differs from that of `opnd_a`.
- R6: All outputs depend only on the present inputs. There is no clock and no stored state, and the outputs settle within the same time step as an input change.
- R7: The block computes the functions of R1–R3 and R5 for every WIDTH that is a multiple of 4. This holds at WIDTH=8 over every combination of operands, mode and carry-in.
- R8: With `sub_mode`=1, `carry_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand (minuend in subtract mode) |
| opnd_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| carry_in | input | 1 | Carry into the lowest bit in add mode; ignored in subtract mode |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top slice; in subtract mode 1 means no borrow |
| ovf_signed | output | 1 | Two's-complement overflow of the result |

## Verification
The built-in checks are immediate assertions evaluated whenever the inputs change. They assume that all four inputs hold known 0/1 values, and they skip any evaluation in which an input is unknown. The bench leaves the inputs undriven only before its first vector, and after that it always applies fully defined values. The stimulus stays within these assumptions in three ways. At 8 bits, it sweeps every operand pair under all four mode and carry-in combinations. At 16 bits, it uses seeded random operands and adds directed patterns that stress the slice boundaries, the borrow edge where the operands are equal, and the signed limits. In subtract mode it also toggles `carry_in` with the operands held fixed, to show that the carry-in is ignored.

// File: rtl/gra_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the group-lookahead adder.
// Assumes: slice width is fixed at 4 bits; the top width is a multiple of it.
package gra_pkg;
    localparam int GRP_W = 4;

    // Majority of three bits: the carry rule of a single full-adder position.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction
endpackage

// File: rtl/gra_pg_cell.sv
`timescale 1ns/1ps
// Module: per-bit generate/propagate cell.
// Produces the generate term (both inputs high) and the half-sum propagate term.
// Assumes: inputs are the A bit and the already-conditioned B bit.
module gra_pg_cell (
    input  logic a_i,
    input  logic b_i,
    output logic g_o,
    output logic p_o
);
    // Form generate and propagate from the two operand bits.
    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i ^ b_i;
    end
endmodule

// File: rtl/gra_operand_cond.sv
`timescale 1ns/1ps
// Module: operand conditioning for add/subtract.
// In subtract mode B is inverted and the initial carry is forced to 1;
// in add mode B and the external carry-in pass through unchanged.
// Assumes: nothing beyond known input values.
module gra_operand_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] b_eff_o,
    output logic             c0_o
);
    // Select true or inverted B and the effective lowest carry.
    always_comb begin
        b_eff_o = sub_i ? ~b_i : b_i;
        c0_o    = sub_i ? 1'b1 : cin_i;
    end

    // Checks: subtract mode overrides the carry-in; every B bit flips with the mode.
    always_comb begin
        if (!$isunknown({b_i, sub_i, cin_i})) begin
            // R8
            sub_forces_carry_chk: assert (!sub_i || c0_o)
                else $error("subtract mode did not force the initial carry");
            // R2
            b_invert_chk: assert ((b_eff_o ^ b_i) == {WIDTH{sub_i}})
                else $error("effective B operand not conditioned by mode");
        end
    end
endmodule

// File: rtl/gra_cla_group.sv
`timescale 1ns/1ps
// Module: one lookahead slice of GW bits.
// Each internal carry is a flat sum of products of generate/propagate terms
// and the slice carry-in; no carry depends on another carry inside the slice.
// Also outputs the carry into the top bit, for signed overflow detection.
// Assumes: b_i is already conditioned for the chosen operation.
module gra_cla_group #(
    parameter int GW = gra_pkg::GRP_W
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          c_i,
    output logic [GW-1:0] s_o,
    output logic          c_o,
    output logic          c_top_o
);
    logic [GW-1:0] gen;
    logic [GW-1:0] prop;
    logic [GW:0]   carry;

    // Per-bit generate/propagate cells.
    for (genvar i = 0; i < GW; i++) begin : g_bit
        gra_pg_cell u_pg (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .g_o (gen[i]),
            .p_o (prop[i])
        );
    end

    // Lookahead: carry i is OR over every source (carry-in or a generate) of
    // that source ANDed with all propagates between it and bit i.
    always_comb begin
        logic prod;
        carry[0] = c_i;
        for (int i = 1; i <= GW; i++) begin
            carry[i] = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod = (j == 0) ? c_i : gen[j-1];
                for (int k = j; k < i; k++) begin
                    prod = prod & prop[k];
                end
                carry[i] = carry[i] | prod;
            end
        end
    end

    // Sum bits and slice outputs.
    always_comb begin
        s_o     = prop ^ carry[GW-1:0];
        c_o     = carry[GW];
        c_top_o = carry[GW-1];
    end

    // Check: each lookahead carry matches the full-adder majority rule.
    always_comb begin
        if (!$isunknown({a_i, b_i, c_i})) begin
            for (int i = 0; i < GW; i++) begin
                // R4
                carry_major_chk: assert (carry[i+1] == gra_pkg::maj3(a_i[i], b_i[i], carry[i]))
                    else $error("lookahead carry %0d disagrees with majority rule", i + 1);
            end
        end
    end
endmodule

// File: rtl/gra_addsub.sv
`timescale 1ns/1ps
// Module: top of the group-lookahead adder/subtractor.
// Chains WIDTH/4 lookahead slices; the carry ripples slice to slice.
// sub_mode=1 computes A + ~B + 1; carry_out=1 then means no borrow.
// Assumes: WIDTH is a positive multiple of 4; purely combinational.
module gra_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sub_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf_signed
);
    localparam int GW   = gra_pkg::GRP_W;
    localparam int NGRP = WIDTH / GW;

    logic [WIDTH-1:0] b_eff;
    logic             c_first;
    logic [NGRP:0]    grp_c;
    logic [NGRP-1:0]  grp_top;

    // Operand conditioning for the selected operation.
    gra_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_i     (opnd_b),
        .sub_i   (sub_mode),
        .cin_i   (carry_in),
        .b_eff_o (b_eff),
        .c0_o    (c_first)
    );

    assign grp_c[0] = c_first;

    // Slice chain: carry out of slice k feeds slice k+1.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        gra_cla_group #(.GW(GW)) u_grp (
            .a_i     (opnd_a[k*GW +: GW]),
            .b_i     (b_eff[k*GW +: GW]),
            .c_i     (grp_c[k]),
            .s_o     (result[k*GW +: GW]),
            .c_o     (grp_c[k+1]),
            .c_top_o (grp_top[k])
        );
    end

    // Final carry and signed overflow (carry into MSB differs from carry out).
    always_comb begin
        carry_out  = grp_c[NGRP];
        ovf_signed = grp_c[NGRP] ^ grp_top[NGRP-1];
    end

    // Checks: whole-word arithmetic, borrow meaning and signed range.
    always_comb begin
        logic [WIDTH:0] wide_ref;
        logic           sa;
        logic           sb;
        logic           sr;
        if (!$isunknown({opnd_a, opnd_b, sub_mode, carry_in})) begin
            if (sub_mode)
                wide_ref = {1'b0, opnd_a} + {1'b0, ~opnd_b} + {{WIDTH{1'b0}}, 1'b1};
            else
                wide_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
            sa = opnd_a[WIDTH-1];
            sb = opnd_b[WIDTH-1];
            sr = result[WIDTH-1];
            // R1
            word_result_chk: assert ({carry_out, result} == wide_ref)
                else $error("slice chain result differs from word arithmetic");
            // R3
            no_borrow_chk: assert (!sub_mode || (carry_out == (opnd_a >= opnd_b)))
                else $error("subtract carry does not mean no-borrow");
            // R5
            signed_ovf_chk: assert (ovf_signed ==
                    (sub_mode ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa))))
                else $error("signed overflow flag wrong");
        end
    end
endmodule

// File: tb/tb_gra_addsub.sv
`timescale 1ns/1ps
// Bench: seeded random plus directed vectors at 16 bits, exhaustive at 8 bits.
module tb_gra_addsub;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [15:0] a16, b16, r16;
    logic        s16, c16, co16, ov16;
    logic [7:0]  a8, b8, r8;
    logic        s8, c8, co8, ov8;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    gra_addsub #(.WIDTH(16)) dut (
        .opnd_a(a16), .opnd_b(b16), .sub_mode(s16), .carry_in(c16),
        .result(r16), .carry_out(co16), .ovf_signed(ov16)
    );

    gra_addsub #(.WIDTH(8)) dut_w8 (
        .opnd_a(a8), .opnd_b(b8), .sub_mode(s8), .carry_in(c8),
        .result(r8), .carry_out(co8), .ovf_signed(ov8)
    );

    // Reference: returns {ovf, cout, sum} for a width up to 30 bits.
    function automatic longint unsigned ref_calc(input int w, input longint unsigned x,
            input longint unsigned y, input bit sub, input bit cin);
        longint unsigned mask, yy, tot, sum;
        bit cout, ovf, sx, sy, ss;
        mask = (64'd1 << w) - 1;
        yy   = sub ? (~y & mask) : y;
        tot  = x + yy + ((sub || cin) ? 64'd1 : 64'd0);
        sum  = tot & mask;
        cout = tot[w];
        sx = x[w-1]; sy = y[w-1]; ss = sum[w-1];
        ovf = sub ? (sx != sy && ss != sx) : (sx == sy && ss != sx);
        return (longint'(ovf) << (w + 1)) | (longint'(cout) << w) | sum;
    endfunction

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Apply one 16-bit vector and compare all outputs.
    task automatic run16(input logic [15:0] x, input logic [15:0] y, input bit sub, input bit cin,
            input string tag);
        longint unsigned e;
        a16 = x; b16 = y; s16 = sub; c16 = cin;
        #0.5;
        e = ref_calc(16, x, y, sub, cin);
        check(tag, {ov16, co16, r16}, e);
        #0.5;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        a8 = '0; b8 = '0; s8 = 1'b0; c8 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Idle state: all-zero inputs give all-zero outputs (R1).
        run16(16'h0000, 16'h0000, 0, 0, "R1 idle");
        // R4: carry across every slice boundary, and across one boundary.
        run16(16'hFFFF, 16'h0000, 0, 1, "R4 full ripple");
        run16(16'h000F, 16'h0001, 0, 0, "R4 slice boundary");
        run16(16'h0FFF, 16'h0001, 0, 0, "R4 three slices");
        run16(16'hFFFF, 16'hFFFF, 0, 1, "R1 max operands");
        // R3: borrow edge.
        run16(16'h1234, 16'h1234, 1, 0, "R3 equal no borrow");
        run16(16'h1233, 16'h1234, 1, 0, "R3 borrow");
        run16(16'h0000, 16'hFFFF, 1, 0, "R2 wrap difference");
        // R5: signed limits.
        run16(16'h7FFF, 16'h0001, 0, 0, "R5 add positive overflow");
        run16(16'h8000, 16'hFFFF, 0, 0, "R5 add negative overflow");
        run16(16'h8000, 16'h0001, 1, 0, "R5 sub overflow");
        run16(16'h7FFF, 16'hFFFF, 1, 0, "R5 sub overflow neg b");
        run16(16'h7FFF, 16'h7FFF, 1, 0, "R5 sub no overflow");

        // R8: carry_in ignored in subtract mode, same operands both ways.
        for (int i = 0; i < 64; i++) begin
            logic [15:0] x, y;
            logic [17:0] first;
            x = 16'($urandom); y = 16'($urandom);
            a16 = x; b16 = y; s16 = 1'b1; c16 = 1'b0;
            #0.5;
            first = {ov16, co16, r16};
            #0.5;
            c16 = 1'b1;
            #0.5;
            check("R8 carry_in ignored", {ov16, co16, r16}, first);
            #0.5;
        end

        // R6: output follows an input change mid-cycle with no clock edge between.
        @(negedge clk);
        a16 = 16'h00F0; b16 = 16'h0010; s16 = 1'b0; c16 = 1'b0;
        #0.5;
        check("R6 immediate response", {ov16, co16, r16}, ref_calc(16, 16'h00F0, 16'h0010, 0, 0));
        a16 = 16'h00F1;
        #0.5;
        check("R6 follows change", {ov16, co16, r16}, ref_calc(16, 16'h00F1, 16'h0010, 0, 0));

        // Random 16-bit vectors, biased toward slice-boundary patterns.
        for (int i = 0; i < 30000; i++) begin
            logic [15:0] x, y;
            bit sub, cin;
            x = 16'($urandom); y = 16'($urandom);
            if (($urandom % 8) == 0) y = ~x;
            if (($urandom % 16) == 0) y = x;
            sub = 1'($urandom); cin = 1'($urandom);
            run16(x, y, sub, cin, sub ? "R2/R3/R5 random sub" : "R1/R5 random add");
        end

        // R7: exhaustive 8-bit sweep over operands, mode and carry-in.
        for (int m = 0; m < 4; m++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    longint unsigned e;
                    a8 = 8'(x); b8 = 8'(y); s8 = m[1]; c8 = m[0];
                    #0.5;
                    e = ref_calc(8, longint'(x), longint'(y), m[1], m[0]);
                    check("R7 exhaustive 8-bit", {ov8, co8, r8}, e);
                    #0.5;
                end
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule